// File: doc/BRIEF.md
# Frame Buffer Slot Allocator

This block keeps the books for the slot pool of a switch's frame data buffer. A frame that has just arrived has no known class yet, so it first takes a slot in a small holding area. When the switch response supplies the frame's class, the block makes the keep-or-drop decision and charges the frame to one region of the pool. Storing the frames themselves is not part of this block.

Placement follows a fixed order. A class with its own reservation (classes 2 to 7) is charged there first. Classes 0 and 1, and any class whose reservation is used up, go to the shared pool. When the shared pool is also full, the frame is charged to the reservation of its source port. When that is exhausted as well, the frame is dropped. Whatever the outcome, the frame's holding slot is freed.

Every grant returns a region tag. The tag is a 7-bit value `{kind[1:0], idx[4:0]}`. The kind codes are 0 for a class reservation (idx is the class number), 1 for the shared pool (idx is 0) and 2 for a port reservation (idx is the port number). The frame's owner later hands this tag back to free the slot. The size of each region comes from a configuration input.

Top module: `fbuf_slot_alloc`

## Requirements
- R1: After reset, every region counter and the holding area are empty, and every output is low.
- R2: An arrival is accepted (`arr_ok_o`) while the holding area holds fewer than TEMP_SLOTS frames. Otherwise it is refused (`arr_refuse_o`). The outcome appears one cycle after the request.
- R3: A classified frame of class 2 to 7 whose class count is below that class's reserve size is granted tag kind 0, with idx equal to its class.
- R4: A frame of class 0 or 1, or a frame whose class reservation is full, is granted tag kind 1 with idx 0 while the shared count is below the shared size.
- R5: When the shared pool is full, the frame is granted tag kind 2, with idx equal to its source port, while that port's count is below the port reserve size.
- R6: When every eligible region is full, `drop_o` pulses and no grant is made. A dropped frame still frees its holding slot, and so does a granted one.
- R7: A release decrements only the counter named by its tag. That region can then accept one more frame.
- R8: A release that would take a counter below zero, or whose tag names no region, is ignored and pulses `rel_err_o` one cycle later.
- R9: A release and a classification in the same cycle are handled release-first, so the freed slot can serve that classification.
- R10: A classification and an arrival in the same cycle free the holding slot before the arrival is judged, so the arrival is accepted even when the holding area was full.
- R11: Each class is counted on its own, so a full class 2 reservation does not block class 3.
- R12: Grant, tag and drop appear one cycle after the classification request, and grant and drop are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_class_rsv_i | input | 6*CNT_W | Reserve sizes for classes 2..7; class c sits at bits (c-2)*CNT_W |
| cfg_shared_size_i | input | CNT_W | Shared pool size |
| cfg_port_rsv_i | input | CNT_W | Reserve size used for every source port |
| arr_req_i | input | 1 | A frame arrives and asks for a holding slot |
| arr_ok_o | output | 1 | Holding slot given |
| arr_refuse_o | output | 1 | Holding area full; arrival refused |
| cls_req_i | input | 1 | Switch response for a held frame; ignored when nothing is held |
| cls_port_i | input | PORT_W | Source port of the classified frame |
| cls_class_i | input | 3 | Priority class of the classified frame |
| grant_o | output | 1 | Frame placed in a region |
| grant_tag_o | output | 7 | Region tag for the grant |
| drop_o | output | 1 | Frame discarded |
| rel_req_i | input | 1 | Free one slot |
| rel_tag_i | input | 7 | Tag of the region to free |
| rel_err_o | output | 1 | Release ignored: counter underflow or bad tag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a release with a classification: the bench fills the shared pool, then releases a shared slot in the same cycle that a class 0 frame is classified, and expects a shared grant rather than a port grant. The second is an arrival with a classification: the bench fills the holding area, then presents an arrival together with a classification, and expects the arrival to be accepted alongside the grant.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    localparam int TAG_W          = 7;
    localparam int IDX_W          = 5;
    localparam int NUM_CLASSES    = 8;
    localparam int FIRST_RSV_CLS  = 2;
    localparam int NUM_RSV_CLS    = NUM_CLASSES - FIRST_RSV_CLS;

    typedef enum logic [1:0] {
        RGN_CLASS  = 2'd0,
        RGN_SHARED = 2'd1,
        RGN_PORT   = 2'd2,
        RGN_NONE   = 2'd3
    } rgn_kind_e;

    typedef struct packed {
        rgn_kind_e         kind;
        logic [IDX_W-1:0]  idx;
    } rgn_tag_t;
endpackage

// File: rtl/fbuf_rsv_counter.sv
module fbuf_rsv_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] level_o,
    output logic             underflow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        underflow_o = dec_i && (st_q.cnt == '0);
        level_o     = (dec_i && !underflow_o) ? st_q.cnt - CNT_W'(1) : st_q.cnt;
        st_d.cnt    = inc_i ? level_o + CNT_W'(1) : level_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Counter never wraps to zero on a charge
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> st_q.cnt != '0);

    // An ignored release leaves an empty counter empty
    assert_underflow_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !inc_i) |=> st_q.cnt == '0);
endmodule

// File: rtl/fbuf_temp_region.sv
module fbuf_temp_region #(
    parameter int TEMP_SLOTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arr_req_i,
    input  logic cls_req_i,
    output logic arr_ok_o,
    output logic arr_refuse_o,
    output logic cls_held_o
);
    localparam int TMP_W = $clog2(TEMP_SLOTS + 1);
    localparam logic [TMP_W-1:0] CAP = TMP_W'(TEMP_SLOTS);

    typedef struct packed {
        logic [TMP_W-1:0] cnt;
    } tmp_state_t;

    tmp_state_t st_d, st_q;
    logic [TMP_W-1:0] after_free;

    always_comb begin
        st_d         = st_q;
        cls_held_o   = cls_req_i && (st_q.cnt != '0);
        after_free   = cls_held_o ? st_q.cnt - TMP_W'(1) : st_q.cnt;
        arr_ok_o     = arr_req_i && (after_free < CAP);
        arr_refuse_o = arr_req_i && !arr_ok_o;
        st_d.cnt     = arr_ok_o ? after_free + TMP_W'(1) : after_free;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_temp_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CAP);

    assert_refuse_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_refuse_o |-> (st_q.cnt == CAP) && !cls_held_o);
endmodule

// File: rtl/fbuf_place_decide.sv
module fbuf_place_decide
    import fbuf_pkg::*;
#(
    parameter int NUM_PORTS = 24,
    parameter int PORT_W    = 5
) (
    input  logic [2:0]             cls_class_i,
    input  logic [PORT_W-1:0]      cls_port_i,
    input  logic [NUM_RSV_CLS-1:0] class_room_i,
    input  logic                   shared_room_i,
    input  logic [NUM_PORTS-1:0]   port_room_i,
    output rgn_tag_t               tag_o
);
    logic class_hit;
    logic port_hit;

    always_comb begin
        class_hit = 1'b0;
        for (int c = 0; c < NUM_RSV_CLS; c++) begin
            if (cls_class_i == 3'(c + FIRST_RSV_CLS)) class_hit = class_room_i[c];
        end
        port_hit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cls_port_i == PORT_W'(p)) port_hit = port_room_i[p];
        end

        tag_o = '{kind: RGN_NONE, idx: '0};
        if (class_hit) begin
            tag_o.kind = RGN_CLASS;
            tag_o.idx  = IDX_W'(cls_class_i);
        end else if (shared_room_i) begin
            tag_o.kind = RGN_SHARED;
        end else if (port_hit) begin
            tag_o.kind = RGN_PORT;
            tag_o.idx  = IDX_W'(cls_port_i);
        end
    end
endmodule

// File: rtl/fbuf_slot_alloc.sv
module fbuf_slot_alloc
    import fbuf_pkg::*;
#(
    parameter int NUM_PORTS  = 24,
    parameter int CNT_W      = 10,
    parameter int TEMP_SLOTS = 8,
    localparam int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RSV_CLS*CNT_W-1:0] cfg_class_rsv_i,
    input  logic [CNT_W-1:0]           cfg_shared_size_i,
    input  logic [CNT_W-1:0]           cfg_port_rsv_i,
    input  logic                       arr_req_i,
    output logic                       arr_ok_o,
    output logic                       arr_refuse_o,
    input  logic                       cls_req_i,
    input  logic [PORT_W-1:0]          cls_port_i,
    input  logic [2:0]                 cls_class_i,
    output logic                       grant_o,
    output logic [TAG_W-1:0]           grant_tag_o,
    output logic                       drop_o,
    input  logic                       rel_req_i,
    input  logic [TAG_W-1:0]           rel_tag_i,
    output logic                       rel_err_o
);
    typedef struct packed {
        logic     arr_ok;
        logic     arr_refuse;
        logic     grant;
        logic     drop;
        rgn_tag_t tag;
        logic     rel_err;
    } out_state_t;

    out_state_t out_d, out_q;

    rgn_tag_t rel_tag;
    rgn_tag_t place_tag;

    logic [NUM_RSV_CLS-1:0] class_dec, class_inc, class_uf, class_room;
    logic [NUM_PORTS-1:0]   port_dec, port_inc, port_uf, port_room;
    logic                   shared_dec, shared_inc, shared_uf, shared_room;
    logic [CNT_W-1:0]       class_lvl [NUM_RSV_CLS];
    logic [CNT_W-1:0]       port_lvl  [NUM_PORTS];
    logic [CNT_W-1:0]       shared_lvl;
    logic                   rel_bad;
    logic                   arr_ok, arr_refuse, cls_held;

    assign rel_tag = rgn_tag_t'(rel_tag_i);

    // Release decode: exactly one counter or none
    always_comb begin
        for (int c = 0; c < NUM_RSV_CLS; c++) begin
            class_dec[c] = rel_req_i && (rel_tag.kind == RGN_CLASS)
                           && (rel_tag.idx == IDX_W'(c + FIRST_RSV_CLS));
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            port_dec[p] = rel_req_i && (rel_tag.kind == RGN_PORT)
                          && (rel_tag.idx == IDX_W'(p));
        end
        shared_dec = rel_req_i && (rel_tag.kind == RGN_SHARED) && (rel_tag.idx == '0);
        rel_bad    = rel_req_i && !(|class_dec) && !(|port_dec) && !shared_dec;
    end

    fbuf_temp_region #(.TEMP_SLOTS(TEMP_SLOTS)) temp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .arr_req_i    (arr_req_i),
        .cls_req_i    (cls_req_i),
        .arr_ok_o     (arr_ok),
        .arr_refuse_o (arr_refuse),
        .cls_held_o   (cls_held)
    );

    for (genvar c = 0; c < NUM_RSV_CLS; c++) begin : g_class
        fbuf_rsv_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .dec_i       (class_dec[c]),
            .inc_i       (class_inc[c]),
            .level_o     (class_lvl[c]),
            .underflow_o (class_uf[c])
        );
        assign class_room[c] = class_lvl[c] < cfg_class_rsv_i[c*CNT_W +: CNT_W];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fbuf_rsv_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .dec_i       (port_dec[p]),
            .inc_i       (port_inc[p]),
            .level_o     (port_lvl[p]),
            .underflow_o (port_uf[p])
        );
        assign port_room[p] = port_lvl[p] < cfg_port_rsv_i;
    end

    fbuf_rsv_counter #(.CNT_W(CNT_W)) shared_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_i       (shared_dec),
        .inc_i       (shared_inc),
        .level_o     (shared_lvl),
        .underflow_o (shared_uf)
    );
    assign shared_room = shared_lvl < cfg_shared_size_i;

    fbuf_place_decide #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) decide_i (
        .cls_class_i   (cls_class_i),
        .cls_port_i    (cls_port_i),
        .class_room_i  (class_room),
        .shared_room_i (shared_room),
        .port_room_i   (port_room),
        .tag_o         (place_tag)
    );

    // Charge the chosen counter
    always_comb begin
        for (int c = 0; c < NUM_RSV_CLS; c++) begin
            class_inc[c] = cls_held && (place_tag.kind == RGN_CLASS)
                           && (place_tag.idx == IDX_W'(c + FIRST_RSV_CLS));
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            port_inc[p] = cls_held && (place_tag.kind == RGN_PORT)
                          && (place_tag.idx == IDX_W'(p));
        end
        shared_inc = cls_held && (place_tag.kind == RGN_SHARED);
    end

    always_comb begin
        out_d            = '0;
        out_d.arr_ok     = arr_ok;
        out_d.arr_refuse = arr_refuse;
        out_d.grant      = cls_held && (place_tag.kind != RGN_NONE);
        out_d.drop       = cls_held && (place_tag.kind == RGN_NONE);
        out_d.tag        = out_d.grant ? place_tag : '0;
        out_d.rel_err    = rel_bad || (|class_uf) || (|port_uf) || shared_uf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign arr_ok_o     = out_q.arr_ok;
    assign arr_refuse_o = out_q.arr_refuse;
    assign grant_o      = out_q.grant;
    assign grant_tag_o  = out_q.tag;
    assign drop_o       = out_q.drop;
    assign rel_err_o    = out_q.rel_err;

    assert_grant_drop_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.grant && out_q.drop));

    assert_result_follows_cls_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.grant || out_q.drop) |-> $past(cls_req_i));

    assert_class_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.grant && out_q.tag.kind == RGN_CLASS) |->
            (out_q.tag.idx >= IDX_W'(FIRST_RSV_CLS)) && (out_q.tag.idx < IDX_W'(NUM_CLASSES)));

    assert_rel_err_follows_rel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.rel_err |-> $past(rel_req_i));

    assert_arr_outcome_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.arr_ok && out_q.arr_refuse));
endmodule

// File: tb/fbuf_slot_alloc_tb.sv
`timescale 1ns/1ps
module fbuf_slot_alloc_tb_top;
    localparam int CNT_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6*CNT_W-1:0] cfg_class_rsv = {6{10'd1}};
    logic [CNT_W-1:0] cfg_shared = 10'd2;
    logic [CNT_W-1:0] cfg_port = 10'd1;
    logic        arr_req_i = 1'b0, cls_req_i = 1'b0, rel_req_i = 1'b0;
    logic [4:0]  cls_port_i = '0;
    logic [2:0]  cls_class_i = '0;
    logic [6:0]  rel_tag_i = '0;
    logic        arr_ok_o, arr_refuse_o, grant_o, drop_o, rel_err_o;
    logic [6:0]  grant_tag_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fbuf_slot_alloc dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_class_rsv_i   (cfg_class_rsv),
        .cfg_shared_size_i (cfg_shared),
        .cfg_port_rsv_i    (cfg_port),
        .arr_req_i         (arr_req_i),
        .arr_ok_o          (arr_ok_o),
        .arr_refuse_o      (arr_refuse_o),
        .cls_req_i         (cls_req_i),
        .cls_port_i        (cls_port_i),
        .cls_class_i       (cls_class_i),
        .grant_o           (grant_o),
        .grant_tag_o       (grant_tag_o),
        .drop_o            (drop_o),
        .rel_req_i         (rel_req_i),
        .rel_tag_i         (rel_tag_i),
        .rel_err_o         (rel_err_o)
    );

    function automatic logic [6:0] mk_tag(input logic [1:0] kind, input logic [4:0] idx);
        return {kind, idx};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request cycle; outputs are sampled at the following falling edge
    task automatic op(input logic arr, input logic cls, input logic [4:0] port,
                      input logic [2:0] klass, input logic rel, input logic [6:0] tag);
        arr_req_i = arr; cls_req_i = cls; cls_port_i = port; cls_class_i = klass;
        rel_req_i = rel; rel_tag_i = tag;
        @(posedge clk);
        @(negedge clk);
        arr_req_i = 1'b0; cls_req_i = 1'b0; rel_req_i = 1'b0;
    endtask

    task automatic exp_cls(input string req, input logic g, input logic d, input logic [6:0] tag);
        chk(req, {29'd0, g, d, rel_err_o}, {29'd0, g, d, 1'b0});
        chk(req, {25'd0, grant_tag_o}, {25'd0, tag});
    endtask

    task automatic t_reset;
        chk("R1", {26'd0, arr_ok_o, arr_refuse_o, grant_o, drop_o, rel_err_o, |grant_tag_o}, 32'd0);
    endtask

    task automatic t_fill_temp;
        for (int i = 0; i < 8; i++) begin
            op(1, 0, 0, 0, 0, 0);
            chk("R2", {30'd0, arr_ok_o, arr_refuse_o}, 32'b10);
        end
        op(1, 0, 0, 0, 0, 0);
        chk("R2", {30'd0, arr_ok_o, arr_refuse_o}, 32'b01);
    endtask

    task automatic t_arr_with_cls;
        op(1, 1, 5'd0, 3'd2, 0, 0);
        chk("R10", {30'd0, arr_ok_o, arr_refuse_o}, 32'b10);
        exp_cls("R3", 1, 0, mk_tag(2'd0, 5'd2));
    endtask

    task automatic t_fallthrough;
        op(0, 1, 5'd0, 3'd2, 0, 0);
        exp_cls("R4", 1, 0, mk_tag(2'd1, 5'd0));
        op(0, 1, 5'd0, 3'd3, 0, 0);
        exp_cls("R11", 1, 0, mk_tag(2'd0, 5'd3));
        op(0, 1, 5'd1, 3'd0, 0, 0);
        exp_cls("R4", 1, 0, mk_tag(2'd1, 5'd0));
        op(0, 1, 5'd5, 3'd2, 0, 0);
        exp_cls("R5", 1, 0, mk_tag(2'd2, 5'd5));
        op(0, 1, 5'd5, 3'd2, 0, 0);
        exp_cls("R6", 0, 1, 7'd0);
    endtask

    task automatic t_temp_freed;
        for (int i = 0; i < 5; i++) begin
            op(1, 0, 0, 0, 0, 0);
            chk("R6", {31'd0, arr_ok_o}, 32'd1);
        end
        op(1, 0, 0, 0, 0, 0);
        chk("R6", {30'd0, arr_ok_o, arr_refuse_o}, 32'b01);
    endtask

    task automatic t_release;
        op(0, 0, 0, 0, 1, mk_tag(2'd0, 5'd2));
        chk("R7", {31'd0, rel_err_o}, 32'd0);
        op(0, 1, 5'd7, 3'd2, 0, 0);
        exp_cls("R7", 1, 0, mk_tag(2'd0, 5'd2));
        op(0, 0, 0, 0, 1, mk_tag(2'd2, 5'd5));
        chk("R7", {31'd0, rel_err_o}, 32'd0);
        op(0, 0, 0, 0, 1, mk_tag(2'd2, 5'd5));
        chk("R8", {31'd0, rel_err_o}, 32'd1);
        op(0, 1, 5'd5, 3'd2, 0, 0);
        exp_cls("R8", 1, 0, mk_tag(2'd2, 5'd5));
        op(0, 1, 5'd5, 3'd2, 0, 0);
        exp_cls("R8", 0, 1, 7'd0);
    endtask

    task automatic t_bad_tags;
        op(0, 0, 0, 0, 1, mk_tag(2'd3, 5'd0));
        chk("R8", {31'd0, rel_err_o}, 32'd1);
        op(0, 0, 0, 0, 1, mk_tag(2'd0, 5'd1));
        chk("R8", {31'd0, rel_err_o}, 32'd1);
        op(0, 0, 0, 0, 1, mk_tag(2'd0, 5'd7));
        chk("R8", {31'd0, rel_err_o}, 32'd1);
    endtask

    task automatic t_rel_with_cls;
        op(0, 1, 5'd9, 3'd0, 1, mk_tag(2'd1, 5'd0));
        exp_cls("R9", 1, 0, mk_tag(2'd1, 5'd0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_temp();
        t_arr_with_cls();
        t_fallthrough();
        t_temp_freed();
        t_release();
        t_bad_tags();
        t_rel_with_cls();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule